// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of one of two free-running 16-bit timer values when a chosen event appears on an external capture input. The event may be a falling edge, a rising edge, every fourth rising edge or every sixteenth rising edge. A 4-bit mode field, written through a simple write port, selects the event. A separate select input chooses which timer is sampled.

The capture input is brought into the clock domain by a two-flop synchronizer. Edges are then found by comparing the synchronized sample with the one from the previous clock. Each capture raises an interrupt flag, and the flag stays set until a clear strobe arrives. The snapshot is always presented as one 16-bit word, so a reader never sees a value that is half old and half new. A later capture overwrites an unread value.

The counter that divides rising edges is reset only when the unit is off or in a mode that is not a capture mode. A direct switch between the two divide settings keeps the partial count, so the first capture after the switch can come early.

Top module: `cap_unit`

## Requirements
- R1: After reset the captured value reads 0, the flag is 0 and the mode is off (code 0000).
- R2: In mode 0100 a falling edge on the capture input loads the selected timer value. The value is the one present on the third rising clock edge after the input changes, which is two synchronizer stages plus one edge-detect stage.
- R3: In mode 0101 every rising edge of the capture input triggers a capture, with the same latency as R2.
- R4: In mode 0110 a capture is made on every fourth rising edge counted since the counter was last cleared.
- R5: In mode 0111 a capture is made on every sixteenth rising edge counted since the counter was last cleared.
- R6: Every capture sets the flag. The flag stays set until flag_clr_i is high. When a clear and a capture fall in the same cycle, the flag ends up set.
- R7: A new capture overwrites the previous value whether or not it was read.
- R8: Code 0000 and every code other than 0100 to 0111 make no capture and clear the edge counter. After a return to mode 0110, four further rising edges are needed for a capture.
- R9: A direct write from 0111 to 0110, or from 0110 to 0111, keeps the edge count. If the kept count already has at least limit-1 edges, the next rising edge captures at once.
- R10: tmr_sel_i = 0 samples tmr_a_i and tmr_sel_i = 1 samples tmr_b_i, taken in the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 1 | Capture input, asynchronous |
| tmr_a_i | input | 16 | Timer source 0 |
| tmr_b_i | input | 16 | Timer source 1 |
| tmr_sel_i | input | 1 | Timer source select |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 4 | New mode code |
| flag_clr_i | input | 1 | Flag clear strobe |
| cap_val_o | output | 16 | Captured timer value, whole word |
| flag_o | output | 1 | Capture interrupt flag |

## Verification
The bench switches from the divide-by-16 setting to the divide-by-4 setting partway through a count. A design that cleared the counter on this switch would wait four more edges instead of capturing on the next edge. It also passes through the off code and through an unused code, and then checks that a full four edges are needed again. A design that kept the count there would capture early. A clear strobe held across a capture cycle shows whether the clear wrongly wins over the capture. Because the reference model is compared on every clock, a synchronizer that is one stage short or one stage long shows up as a captured value that is off by one timer tick.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 4'b0000,
    MODE_FALL  = 4'b0100,
    MODE_RISE  = 4'b0101,
    MODE_DIV_L = 4'b0110,
    MODE_DIV_H = 4'b0111
  } cap_mode_e;

  function automatic logic is_cap_mode(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_div_mode(input logic [MODE_W-1:0] m);
    return m[3:1] == 3'b011;
  endfunction
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

  // R2
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/cap_presc.sv
module cap_presc #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16,
  localparam int CNT_W = $clog2(DIV_HI)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_i,
  input  logic hi_i,
  input  logic rise_i,
  output logic evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1 = hi_i ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
  // count kept across a divide switch: >= lets a stale count fire at once
  assign evt_o  = en_i && div_i && rise_i && (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i)               cnt_q <= '0;
    else if (div_i && rise_i)     cnt_q <= evt_o ? '0 : cnt_q + 1'b1;
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  // R4
  evt_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> rise_i);
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int TW     = 16,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_pin_i,
  input  logic [TW-1:0]     tmr_a_i,
  input  logic [TW-1:0]     tmr_b_i,
  input  logic              tmr_sel_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              flag_clr_i,
  output logic [TW-1:0]     cap_val_o,
  output logic              flag_o
);
  logic [MODE_W-1:0] mode_q;
  logic [TW-1:0]     cap_q, tmr_mux;
  logic              flag_q, rise, fall, div_evt, cap_en, cap_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_OFF;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  cap_sync_edge u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cap_pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cap_en = is_cap_mode(mode_q);

  cap_presc #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cap_en),
    .div_i (is_div_mode(mode_q)),
    .hi_i  (mode_q[0]),
    .rise_i(rise),
    .evt_o (div_evt)
  );

  always_comb begin
    unique case (mode_q)
      MODE_FALL:  cap_evt = fall;
      MODE_RISE:  cap_evt = rise;
      MODE_DIV_L,
      MODE_DIV_H: cap_evt = div_evt;
      default:    cap_evt = 1'b0;
    endcase
  end

  assign tmr_mux = tmr_sel_i ? tmr_b_i : tmr_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= tmr_mux;
      // capture beats clear
      if (cap_evt)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_val_o = cap_q;
  assign flag_o    = flag_q;

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> flag_o);
  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);
  // R10
  cap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_val_o == $past(tmr_mux));
  // R8
  off_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en |=> $stable(cap_val_o));
endmodule

// File: tb/sim_cap_unit.sv
module sim_cap_unit;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cap_pin_i = 1'b0, tmr_sel_i = 1'b0;
  logic [15:0] tmr_a_i = '0, tmr_b_i = 16'h8000;
  logic        mode_we_i = 1'b0, flag_clr_i = 1'b0;
  logic [3:0]  mode_wdata_i = '0;
  logic [15:0] cap_val_o;
  logic        flag_o;

  int n_chk = 0, n_err = 0;
  string req = "R1";

  always #5 clk_i = ~clk_i;

  cap_unit u0 (.*);

  // behavioural reference
  logic [3:0]  m_mode;
  int          m_cnt;
  logic [15:0] m_cap;
  logic        m_flag;
  bit          hist[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cnt = 0; m_cap = 0; m_flag = 0;
      hist = {1'b0, 1'b0, 1'b0, 1'b0};
    end else begin
      bit r, f, hit;
      int lim;
      hist.push_back(cap_pin_i);
      if (hist.size() > 8) void'(hist.pop_front());
      r = hist[hist.size()-3] && !hist[hist.size()-4];
      f = !hist[hist.size()-3] && hist[hist.size()-4];
      lim = (m_mode == 4'b0111) ? 16 : 4;
      hit = 0;
      case (m_mode)
        4'b0100: hit = f;
        4'b0101: hit = r;
        4'b0110, 4'b0111: hit = r && (m_cnt >= lim - 1);
        default: hit = 0;
      endcase
      if (hit) m_cap = tmr_sel_i ? tmr_b_i : tmr_a_i;
      if (hit) m_flag = 1; else if (flag_clr_i) m_flag = 0;
      if (m_mode < 4 || m_mode > 7) m_cnt = 0;
      else if (m_mode >= 6 && r) m_cnt = hit ? 0 : m_cnt + 1;
      if (mode_we_i) m_mode = mode_wdata_i;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    chk(cap_val_o == m_cap, {req, " value"}, cap_val_o, m_cap);
    chk(flag_o == m_flag, {req, " flag"}, flag_o, m_flag);
    tmr_a_i = tmr_a_i + 1;
    tmr_b_i = tmr_b_i + 3;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_we_i = 1; mode_wdata_i = m; tick(); mode_we_i = 0;
  endtask

  task automatic clr();
    flag_clr_i = 1; tick(); flag_clr_i = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cap_pin_i = 1; ticks(4); cap_pin_i = 0; ticks(4);
    end
  endtask

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1
    req = "R1"; tick();
    chk(cap_val_o == 0 && flag_o == 0, "R1 reset", {cap_val_o, 7'b0, flag_o}, 0);
    pulse(2);
    chk(flag_o == 0, "R1 off after reset", flag_o, 0);

    // R3
    req = "R3"; set_mode(4'b0101); pulse(1);
    chk(flag_o == 1, "R3 rise flag", flag_o, 1);
    // R6
    req = "R6"; ticks(5);
    chk(flag_o == 1, "R6 flag held", flag_o, 1);
    clr();
    chk(flag_o == 0, "R6 flag cleared", flag_o, 0);

    // R2
    req = "R2"; set_mode(4'b0100);
    cap_pin_i = 1; ticks(6);
    chk(flag_o == 0, "R2 no capture on rise", flag_o, 0);
    cap_pin_i = 0; ticks(6);
    chk(flag_o == 1, "R2 fall flag", flag_o, 1);
    clr();

    // R10
    req = "R10"; tmr_sel_i = 1; set_mode(4'b0101); pulse(1);
    chk(cap_val_o[15] == 1, "R10 timer b chosen", cap_val_o, m_cap);
    tmr_sel_i = 0; clr();

    // R7
    req = "R7"; v = cap_val_o; pulse(1);
    chk(cap_val_o != v, "R7 overwrite", cap_val_o, m_cap);

    // R6 clear held across a capture
    req = "R6"; flag_clr_i = 1; cap_pin_i = 1; ticks(6); cap_pin_i = 0; ticks(2);
    flag_clr_i = 0; ticks(2);

    // R4
    req = "R4"; set_mode(4'b0000); clr(); set_mode(4'b0110);
    pulse(3);
    chk(flag_o == 0, "R4 three edges", flag_o, 0);
    pulse(1);
    chk(flag_o == 1, "R4 fourth edge", flag_o, 1);
    clr(); pulse(4);

    // R5
    req = "R5"; set_mode(4'b0000); clr(); set_mode(4'b0111);
    pulse(15);
    chk(flag_o == 0, "R5 fifteen edges", flag_o, 0);
    pulse(1);
    chk(flag_o == 1, "R5 sixteenth edge", flag_o, 1);
    clr();

    // R9
    req = "R9"; pulse(9); set_mode(4'b0110); clr();
    pulse(1);
    chk(flag_o == 1, "R9 stale count fires", flag_o, 1);
    clr();

    // R8
    req = "R8"; pulse(2); set_mode(4'b0000); pulse(3); set_mode(4'b0110);
    pulse(3);
    chk(flag_o == 0, "R8 count cleared by off", flag_o, 0);
    set_mode(4'b1010); v = cap_val_o; pulse(5);
    chk(flag_o == 0 && cap_val_o == v, "R8 unused code ignores edges", cap_val_o, v);
    set_mode(4'b0110); pulse(3);
    chk(flag_o == 0, "R8 count cleared by unused code", flag_o, 0);
    pulse(1);
    chk(flag_o == 1, "R8 fourth edge after return", flag_o, 1);
    ticks(3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule